// File: doc/BRIEF.md
# Jackknife Multi-Histogram Accumulator

The block accumulates a stream of binned pair events into a set of histograms, one for each jackknife subsample. Each event carries a bin index, a subsample label and a two-bit slot taken from the low bits of the pair's inner loop index. The event adds one to its bin in every histogram except the one numbered by its label. An event whose label names no histogram adds one to all of them. Each histogram is split into four interleaved counter banks, and the slot picks the bank. In a pipelined implementation, back-to-back events that land in the same bin then fall into different banks, so no read-modify-write chain forms across neighbouring events.

A start pulse clears every counter before a run. After the last event a flush pulse begins the readout. For every histogram and bin the four banks are added as a pair of pairwise sums. The block then emits one word per cycle, histogram by histogram, and marks the final word. Using the counts to form a correlation estimate is outside this block.

Top module: `jk_hist_acc`

## Requirements
- R1: An accepted event (ev_valid high, not reading out, no start) adds one to bin ev_bin of every histogram whose number differs from ev_label, and leaves the histogram numbered ev_label unchanged.
- R2: An event whose ev_label is NHIST or larger adds one to bin ev_bin of all NHIST histograms.
- R3: ev_slot (0 to 3) selects the bank that counts the event. Any mix of slots is counted in full, including back-to-back events to one bin through one slot. Each output word is (bank0 + bank1) + (bank2 + bank3) for its bin.
- R4: start clears every counter to zero and ends any readout in progress. out_valid and out_last are low in the next cycle. An event in the same cycle as start is dropped.
- R5: A flush taken outside readout starts a readout. The first word appears on out_data with out_valid high one cycle after that edge. Words follow on consecutive cycles, and histogram h, bin b comes at position h*(NBINS+2)+b. An event in the same cycle as the flush is included.
- R6: out_last is high only with the final word (position NHIST*(NBINS+2)-1), and out_valid is low in the cycle after it.
- R7: Events and flush requests presented during a readout are ignored. The counts read by a later flush do not include them.
- R8: Each counter is CW bits wide and wraps modulo 2^CW.
- R9: After reset, out_valid and out_last are low and every counter reads zero.
- R10: An event with ev_bin of NBINS+2 or more changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear all counters, abort readout |
| ev_valid | input | 1 | Event present this cycle |
| ev_bin | input | BINW | Bin index of the event |
| ev_label | input | LBLW | Jackknife subsample label of the event |
| ev_slot | input | 2 | Bank select, low bits of the inner pair index |
| flush | input | 1 | Begin readout of all histograms |
| out_valid | output | 1 | Readout word present |
| out_data | output | CW | Merged bin count |
| out_last | output | 1 | Final readout word |

## Verification
The assertions take for granted that a readout, once started, either runs to its last word or is cut off by start. They count words against NHIST*(NBINS+2) from the first valid word after reset or start. That count is exact only if the block never sees a flush as a new readout while one is in flight. The stimulus presents flush and events during readouts on purpose, so that the word counting and last-word placement stay correct under that traffic. It aborts readouts only through start, and it drives every input between clock edges so that each edge sees stable values.

// File: rtl/jk_hist_acc.sv
module jk_hist_acc #(
  parameter int NHIST = 11,
  parameter int NBINS = 32,
  parameter int CW    = 64,
  parameter int LBLW  = 4,
  parameter int BINW  = $clog2(NBINS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ev_valid,
  input  logic [BINW-1:0] ev_bin,
  input  logic [LBLW-1:0] ev_label,
  input  logic [1:0]      ev_slot,
  input  logic            flush,
  output logic            out_valid,
  output logic [CW-1:0]   out_data,
  output logic            out_last
);

  localparam int NB2   = NBINS + 2;
  localparam int NBANK = 4;
  localparam int TOTAL = NHIST * NB2;
  localparam int HW    = (NHIST > 1) ? $clog2(NHIST) : 1;
  localparam logic [31:0]   TOTAL_W = 32'(TOTAL);
  localparam logic [CW-1:0] ONE_C   = CW'(1);
  localparam logic [HW-1:0] ONE_H   = HW'(1);
  localparam logic [BINW-1:0] ONE_B = BINW'(1);

  logic [CW-1:0]   cnt [NBANK][NHIST][NB2];
  logic            rd;
  logic [HW-1:0]   hp;
  logic [BINW-1:0] bp;
  logic [CW-1:0]   sum_w;
  logic            hp_end, bp_end, bin_ok;

  assign hp_end = (int'(hp) == NHIST - 1);
  assign bp_end = (int'(bp) == NB2 - 1);
  assign bin_ok = (int'(ev_bin) < NB2);
  assign sum_w  = (cnt[0][hp][bp] + cnt[1][hp][bp]) + (cnt[2][hp][bp] + cnt[3][hp][bp]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NBANK; k++)
        for (int h = 0; h < NHIST; h++)
          for (int b = 0; b < NB2; b++)
            cnt[k][h][b] <= '0;
      rd        <= 1'b0;
      hp        <= '0;
      bp        <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (start) begin
      for (int k = 0; k < NBANK; k++)
        for (int h = 0; h < NHIST; h++)
          for (int b = 0; b < NB2; b++)
            cnt[k][h][b] <= '0;
      rd        <= 1'b0;
      hp        <= '0;
      bp        <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (rd) begin
      out_data  <= sum_w;
      out_valid <= 1'b1;
      out_last  <= hp_end && bp_end;
      if (bp_end) begin
        bp <= '0;
        if (hp_end) begin
          hp <= '0;
          rd <= 1'b0;
        end else begin
          hp <= hp + ONE_H;
        end
      end else begin
        bp <= bp + ONE_B;
      end
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (ev_valid && bin_ok)
        for (int h = 0; h < NHIST; h++)
          if (h != int'(ev_label))
            cnt[ev_slot][h][ev_bin] <= cnt[ev_slot][h][ev_bin] + ONE_C;
      if (flush) begin
        rd <= 1'b1;
        hp <= '0;
        bp <= '0;
      end
    end
  end

endmodule

// File: rtl/jk_hist_acc_chk.sv
module jk_hist_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        out_valid,
  input logic        out_last,
  input logic [31:0] total_words
);

  logic [31:0] wc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wc <= '0;
    else if (start)     wc <= '0;
    else if (out_valid) wc <= out_last ? 32'd0 : wc + 32'd1;
  end

  p_last_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (wc == total_words - 32'd1));

  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wc < total_words));

  p_last_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !start) |=> out_valid);

  p_gap_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_start_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!out_valid && !out_last));

endmodule

bind jk_hist_acc jk_hist_acc_chk chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .out_valid   (out_valid),
  .out_last    (out_last),
  .total_words (TOTAL_W)
);

// File: tb/sim_jk_hist_acc.sv
`timescale 1ns/1ps
module sim_jk_hist_acc;
  localparam int NH  = 11;
  localparam int NBN = 32;
  localparam int NB2 = NBN + 2;
  localparam int BW  = 6;
  localparam int LW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0, ev_valid = 1'b0, flush = 1'b0;
  logic [BW-1:0] ev_bin = '0;
  logic [LW-1:0] ev_label = '0;
  logic [1:0]    ev_slot = '0;
  logic          out_valid, out_last;
  logic [63:0]   out_data;

  jk_hist_acc #(.NHIST(NH), .NBINS(NBN), .CW(64), .LBLW(LW), .BINW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ev_valid(ev_valid), .ev_bin(ev_bin),
    .ev_label(ev_label), .ev_slot(ev_slot), .flush(flush),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  logic       s_start = 1'b0, s_ev = 1'b0, s_flush = 1'b0;
  logic [1:0] s_bin = '0, s_label = '0, s_slot = '0;
  logic       s_valid, s_last;
  logic [2:0] s_data;

  jk_hist_acc #(.NHIST(3), .NBINS(2), .CW(3), .LBLW(2), .BINW(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start(s_start), .ev_valid(s_ev), .ev_bin(s_bin),
    .ev_label(s_label), .ev_slot(s_slot), .flush(s_flush),
    .out_valid(s_valid), .out_data(s_data), .out_last(s_last));

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  longint unsigned ref_c [NH][NB2];
  longint unsigned q[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(string req, bit ev, int bin, int lbl, int slot, bit st, bit fl);
    bit ev_v, el;
    longint unsigned ed;
    ev_valid = ev; ev_bin = BW'(bin); ev_label = LW'(lbl); ev_slot = 2'(slot);
    start = st; flush = fl;
    ev_v = 1'b0; el = 1'b0; ed = 0;
    if (st) begin
      for (int h = 0; h < NH; h++) for (int b = 0; b < NB2; b++) ref_c[h][b] = 0;
      q.delete();
    end else if (q.size() > 0) begin
      ed = q.pop_front(); ev_v = 1'b1; el = (q.size() == 0);
    end else begin
      if (ev && bin < NB2)
        for (int h = 0; h < NH; h++) if (h != lbl) ref_c[h][bin]++;
      if (fl)
        for (int h = 0; h < NH; h++) for (int b = 0; b < NB2; b++) q.push_back(ref_c[h][b]);
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, {62'b0, out_valid, out_last}, {62'b0, ev_v, el});
    if (ev_v) chk(req, out_data, ed);
  endtask

  task automatic readout(string req);
    step(req, 0, 0, 0, 0, 0, 1);
    while (q.size() > 0) step(req, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic step1(bit st, bit ev, int bin, int lbl, int slot, bit fl);
    s_start = st; s_ev = ev; s_bin = 2'(bin); s_label = 2'(lbl); s_slot = 2'(slot); s_flush = fl;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {62'b0, out_valid, out_last}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    readout("R9");

    for (int i = 0; i < 200; i++) step("R1", 1, (i * 7 + 3) % NB2, (i * 5) % NH, i % 4, 0, 0);
    readout("R5");

    for (int i = 0; i < 40; i++) step("R2", 1, (i * 3) % NB2, 11 + i % 5, (i + 1) % 4, 0, 0);
    readout("R2");

    for (int i = 0; i < 30; i++) step("R3", 1, 5, 2, 1, 0, 0);
    for (int i = 0; i < 24; i++) step("R3", 1, 6, 7, i % 4, 0, 0);
    readout("R3");

    for (int i = 0; i < 30; i++) step("R10", 1, NB2 + i, 0, i % 4, 0, 0);
    readout("R10");

    step("R7", 1, 9, 4, 2, 0, 1);
    for (int i = 0; q.size() > 0; i++) step("R7", 1, i % NB2, 1, i % 4, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0);
    readout("R7");

    for (int i = 0; i < 10; i++) step("R4", 1, i, 3, i % 4, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step("R4", 0, 0, 0, 0, 0, 0);
    step("R4", 1, 2, 0, 0, 1, 0);
    step("R4", 1, 4, 0, 0, 1, 0);
    readout("R4");

    step1(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 9; i++) step1(0, 1, 1, 3, i % 4, 0);
    step1(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 12; k++) begin
      step1(0, 0, 0, 0, 0, 0);
      chk("R8", {62'b0, s_valid, s_last}, {62'b0, 1'b1, (k == 11)});
      chk("R8", {61'b0, s_data}, (k % 4 == 1) ? 64'd1 : 64'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule